// File: doc/BRIEF.md
# UART Wake-Up Source Controller

This block sits in the always-on part of a UART and decides whether serial activity should pull the system out of a low-power state. It watches five possible causes. The first is a change of level on the clear-to-send pin, in either direction. The other four are strobes from the receive path: a data arrival, the receive FIFO reaching its fill threshold, an RS-485 address match, and a receive-FIFO threshold time-out.

Each cause has its own enable bit and its own sticky status bit. A cause is only recorded while the power-down input is high. The status bits feed one wake request and an interrupt line. The interrupt line is gated by a single interrupt enable. Software learns which cause woke the system by reading the status bits. It then releases the request by writing ones to the matching clear strobes.

The clear-to-send pin is asynchronous. It passes through a synchronizer chain of configurable depth, and a toggle detector compares successive synchronized samples.

Top module: `uart_wake_ctrl`

## Requirements
- R1: After reset, `wake_sts`, `wake_req` and `wake_int` are all zero.
- R2: Status bit positions are: bit 0 clear-to-send toggle, bit 1 data arrival, bit 2 FIFO threshold, bit 3 address match, bit 4 threshold time-out. The enable and clear vectors use the same positions. A receive strobe that is high at a rising edge, while `pwr_down` and the matching enable bit are both high, makes the status bit read 1 after that edge.
- R3: A level change on `cts_pin`, rising or falling, is synchronized through two flip-flops (default depth). If the change is held and `pwr_down` and enable bit 0 stay high, status bit 0 reads 1 after the third rising edge following the change, and not before.
- R4: While `pwr_down` is low, no source event sets any status bit.
- R5: An event whose enable bit is 0 sets no status bit.
- R6: A set status bit stays set until a 1 is written to its clear bit, which makes it read 0 after that edge. Clear bits that are 0 leave their flags untouched.
- R7: If a clear and a qualifying new event for the same bit occur in the same cycle, the bit stays set.
- R8: `wake_req` is high exactly when at least one status bit is set, in the same cycle (default, unregistered output).
- R9: `wake_int` is high exactly when `wake_int_en` is high and at least one status bit is set, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | High while the system is in the low-power state |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| rx_data_evt | input | 1 | Strobe: a receive character arrived |
| rx_lvl_evt | input | 1 | Strobe: receive FIFO reached its threshold |
| rx_addr_evt | input | 1 | Strobe: RS-485 address match |
| rx_tmo_evt | input | 1 | Strobe: receive FIFO threshold time-out |
| src_en | input | 5 | Per-source wake enables (R2 positions) |
| wake_int_en | input | 1 | Wake interrupt enable |
| sts_clr | input | 5 | Write-1-to-clear strobes for the status bits |
| wake_sts | output | 5 | Sticky wake status bits |
| wake_req | output | 1 | Wake request to the power controller |
| wake_int | output | 1 | Wake interrupt |

## Verification
The results fall due at different times. A receive-path strobe shows in its status bit one rising edge after it is sampled. A clear-to-send change shows only after the third edge, because two synchronizer stages and the toggle compare lie in the way. The request and interrupt follow the status bits within the same cycle. The bench drives every input just after a falling edge and keeps a cycle-accurate reference that advances on each rising edge. It compares all outputs at the next falling edge. The directed clear-to-send cases also check explicitly that bit 0 is still 0 after the second edge and is 1 after the third.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
   localparam int unsigned WK_NSRC = 5;

   typedef enum logic [2:0] {
      WK_CTS = 3'd0,
      WK_RXD = 3'd1,
      WK_LVL = 3'd2,
      WK_ADR = 3'd3,
      WK_TMO = 3'd4
   } wk_src_e;

   typedef logic [WK_NSRC-1:0] wk_vec_t;
endpackage

// File: rtl/uart_wake_cts_det.sv
module uart_wake_cts_det #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RST_LVL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic toggle
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("uart_wake_cts_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {SYNC_STAGES{RST_LVL}};
         last  <= RST_LVL;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], pin};
         last  <= chain[TOP];
      end
   end

   // A difference between consecutive synchronized samples is a toggle.
   assign toggle = chain[TOP] ^ last;
endmodule

// File: rtl/uart_wake_flags.sv
module uart_wake_flags #(
   parameter int unsigned NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwr_down,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] en,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] flag
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("uart_wake_flags: NSRC must be at least 1");
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      logic hit;
      assign hit = evt[i] & en[i] & pwr_down;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (hit)    flag[i] <= 1'b1;   // a new event wins over a clear
         else if (clr[i]) flag[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_wake_out.sv
module uart_wake_out #(
   parameter int unsigned NSRC    = 5,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] flag,
   input  logic            int_en,
   output logic            req,
   output logic            irq
);
   logic any_set;
   assign any_set = |flag;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req <= 1'b0;
            irq <= 1'b0;
         end else begin
            req <= any_set;
            irq <= any_set & int_en;
         end
      end
   end else begin : g_comb
      assign req = any_set;
      assign irq = any_set & int_en;
   end
endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
   import uart_wake_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CTS_RST_LVL = 1'b0,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_down,
   input  logic               cts_pin,
   input  logic               rx_data_evt,
   input  logic               rx_lvl_evt,
   input  logic               rx_addr_evt,
   input  logic               rx_tmo_evt,
   input  logic [WK_NSRC-1:0] src_en,
   input  logic               wake_int_en,
   input  logic [WK_NSRC-1:0] sts_clr,
   output logic [WK_NSRC-1:0] wake_sts,
   output logic               wake_req,
   output logic               wake_int
);
   logic    cts_toggle;
   wk_vec_t raw_evt;

   uart_wake_cts_det #(
      .SYNC_STAGES (SYNC_STAGES),
      .RST_LVL     (CTS_RST_LVL)
   ) u_cts (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (cts_pin),
      .toggle (cts_toggle)
   );

   always_comb begin
      raw_evt         = '0;
      raw_evt[WK_CTS] = cts_toggle;
      raw_evt[WK_RXD] = rx_data_evt;
      raw_evt[WK_LVL] = rx_lvl_evt;
      raw_evt[WK_ADR] = rx_addr_evt;
      raw_evt[WK_TMO] = rx_tmo_evt;
   end

   uart_wake_flags #(.NSRC(WK_NSRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .evt      (raw_evt),
      .en       (src_en),
      .clr      (sts_clr),
      .flag     (wake_sts)
   );

   uart_wake_out #(.NSRC(WK_NSRC), .REG_OUT(REG_OUT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag   (wake_sts),
      .int_en (wake_int_en),
      .req    (wake_req),
      .irq    (wake_int)
   );
endmodule

// File: rtl/uart_wake_chk.sv
module uart_wake_chk #(
   parameter int unsigned NSRC    = 5,
   parameter bit          REG_OUT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pwr_down,
   input logic [NSRC-1:0] raw_evt,
   input logic [NSRC-1:0] src_en,
   input logic [NSRC-1:0] sts_clr,
   input logic [NSRC-1:0] wake_sts,
   input logic            wake_int_en,
   input logic            wake_req,
   input logic            wake_int
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (pwr_down && src_en[i] && raw_evt[i]) |=> wake_sts[i]); // R2
      AST_AWAKE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
         (!pwr_down && !wake_sts[i]) |=> !wake_sts[i]); // R4
      AST_DISABLED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_en[i] && !wake_sts[i]) |=> !wake_sts[i]); // R5
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (wake_sts[i] && !sts_clr[i]) |=> wake_sts[i]); // R6
      AST_CLEAR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_clr[i] && pwr_down && src_en[i] && raw_evt[i]) |=> wake_sts[i]); // R7
   end

   if (!REG_OUT) begin : g_comb_chk
      AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (|wake_sts) == wake_req); // R8
      AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         wake_int == ((|wake_sts) && wake_int_en)); // R9
   end else begin : g_reg_chk
      AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (|wake_sts) |=> wake_req); // R8
      AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !wake_int_en |=> !wake_int); // R9
   end
endmodule

bind uart_wake_ctrl uart_wake_chk #(
   .NSRC    (uart_wake_pkg::WK_NSRC),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_down    (pwr_down),
   .raw_evt     (raw_evt),
   .src_en      (src_en),
   .sts_clr     (sts_clr),
   .wake_sts    (wake_sts),
   .wake_int_en (wake_int_en),
   .wake_req    (wake_req),
   .wake_int    (wake_int)
);

// File: tb/tb_uart_wake_ctrl.sv
`timescale 1ns/1ps
module tb_uart_wake_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_down = 1'b0;
   logic       cts_pin = 1'b0;
   logic       rx_data_evt = 1'b0;
   logic       rx_lvl_evt = 1'b0;
   logic       rx_addr_evt = 1'b0;
   logic       rx_tmo_evt = 1'b0;
   logic [4:0] src_en = '0;
   logic       wake_int_en = 1'b0;
   logic [4:0] sts_clr = '0;
   logic [4:0] wake_sts;
   logic       wake_req;
   logic       wake_int;

   int n_chk = 0;
   int n_fail = 0;

   // reference state
   logic [4:0] m_sts = '0;
   logic       m_s1 = 1'b0, m_s2 = 1'b0, m_last = 1'b0;

   always #2.5 clk = ~clk;

   uart_wake_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .cts_pin(cts_pin),
      .rx_data_evt(rx_data_evt), .rx_lvl_evt(rx_lvl_evt),
      .rx_addr_evt(rx_addr_evt), .rx_tmo_evt(rx_tmo_evt),
      .src_en(src_en), .wake_int_en(wake_int_en), .sts_clr(sts_clr),
      .wake_sts(wake_sts), .wake_req(wake_req), .wake_int(wake_int)
   );

   function automatic logic [4:0] next_sts(logic [4:0] cur, logic [4:0] evt,
                                           logic [4:0] en, logic [4:0] clr, logic pd);
      logic [4:0] hit;
      hit = evt & en & {5{pd}};
      return hit | (cur & ~clr);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag);
      logic [4:0] evt;
      @(posedge clk);
      evt    = {rx_tmo_evt, rx_addr_evt, rx_lvl_evt, rx_data_evt, m_s2 ^ m_last};
      m_sts  = next_sts(m_sts, evt, src_en, sts_clr, pwr_down);
      m_last = m_s2;
      m_s2   = m_s1;
      m_s1   = cts_pin;
      @(negedge clk);
      check(tag, "sts", wake_sts, m_sts);
      check("R8", "req", {4'b0, wake_req}, {4'b0, |m_sts});
      check("R9", "int", {4'b0, wake_int}, {4'b0, (|m_sts) & wake_int_en});
   endtask

   task automatic idle();
      rx_data_evt = 0; rx_lvl_evt = 0; rx_addr_evt = 0; rx_tmo_evt = 0;
      sts_clr = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1", "sts", wake_sts, 5'b0);
      check("R1", "req", {4'b0, wake_req}, 5'b0);
      check("R1", "int", {4'b0, wake_int}, 5'b0);
      rst_n = 1'b1;
      step("R1");

      // R2: each receive strobe sets its own bit
      pwr_down = 1; src_en = 5'b11111; wake_int_en = 1;
      rx_lvl_evt = 1; step("R2"); idle();
      check("R2", "lvl bit", wake_sts, 5'b00100);
      rx_tmo_evt = 1; step("R2"); idle();
      check("R2", "tmo bit", wake_sts, 5'b10100);
      // R7: clear with same-cycle event keeps bit
      sts_clr = 5'b10100; rx_lvl_evt = 1; step("R7"); idle();
      check("R7", "clear vs event", wake_sts, 5'b00100);
      // R6: sticky then clear
      step("R6"); check("R6", "sticky", wake_sts, 5'b00100);
      sts_clr = 5'b00100; step("R6"); idle();
      check("R6", "cleared", wake_sts, 5'b0);

      // R4: awake, events ignored
      pwr_down = 0; rx_data_evt = 1; rx_addr_evt = 1; step("R4"); idle();
      check("R4", "no set", wake_sts, 5'b0);
      // R5: disabled source ignored
      pwr_down = 1; src_en = 5'b11101; rx_data_evt = 1; step("R5"); idle();
      check("R5", "disabled", wake_sts, 5'b0);
      // R9: interrupt gated
      src_en = 5'b11111; wake_int_en = 0; rx_addr_evt = 1; step("R9"); idle();
      check("R9", "gated int", {4'b0, wake_int}, 5'b0);
      check("R8", "req set", {4'b0, wake_req}, 5'b1);
      sts_clr = 5'b11111; step("R6"); idle();

      // R3: CTS rising then falling
      cts_pin = 1;
      step("R3"); step("R3");
      check("R3", "not yet rise", {4'b0, wake_sts[0]}, 5'b0);
      step("R3");
      check("R3", "rise toggle", {4'b0, wake_sts[0]}, 5'b1);
      sts_clr = 5'b00001; step("R3"); idle();
      cts_pin = 0;
      step("R3"); step("R3");
      check("R3", "not yet fall", {4'b0, wake_sts[0]}, 5'b0);
      step("R3");
      check("R3", "fall toggle", {4'b0, wake_sts[0]}, 5'b1);
      sts_clr = 5'b11111; step("R6"); idle();

      // constrained random phase
      for (int k = 0; k < 4000; k++) begin
         pwr_down    = ($urandom % 4) != 0;
         src_en      = 5'($urandom);
         wake_int_en = $urandom % 2;
         rx_data_evt = ($urandom % 8) == 0;
         rx_lvl_evt  = ($urandom % 8) == 0;
         rx_addr_evt = ($urandom % 8) == 0;
         rx_tmo_evt  = ($urandom % 8) == 0;
         sts_clr     = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
         if (($urandom % 6) == 0) cts_pin = ~cts_pin;
         step("R2");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule